// File: doc/BRIEF.md
# Abstract Command Instruction Generator

This block turns a 32-bit abstract debug command into a two-word program that a halted hart runs out of a small memory. A one-cycle start pulse brings in the command word together with the selected hart's index and halted state, and the error code and busy flag currently held elsewhere. The block checks the command against a fixed order of rules. It then does one of two things. It may report an updated error code. Or it may write two instruction words and raise the go flag for the selected hart and the busy flag.

A register-transfer command becomes one load or store of the register against a data area. The data area is reached through a signed 12-bit offset from x0. A command without a transfer becomes a no-op. The second word is either a no-op, which lets the hart fall through into the program buffer, or a breakpoint that returns it to the debug loop. Running the program on a core is outside this block.

Top module: `abscmd_gen`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it, every strobe is low and `err_o`, `insn0_o`, `insn1_o` and `go_set_o` are zero.
- R2: Outputs are registered. The result of a start pulse appears on the cycle after it, for one cycle only. Without a start pulse all strobes and data outputs are zero.
- R3: A start pulse with `err_i` not equal to 0 (0 = none) is ignored: no strobe of any kind follows.
- R4: With `err_i` = 0 and `busy_i` high, the only result is `err_we_o` with `err_o` = 1 (busy).
- R5: If neither earlier rule applies and the command type field `cmd_i[31:24]` is not zero, the result is error code 2 (not supported).
- R6: Otherwise, if `hart_halted_i` is low, the result is error code 4 (halt/resume). This rule is checked before any register field rule.
- R7: Otherwise, when the transfer bit `cmd_i[17]` is set and the register number `cmd_i[15:0]` lies outside 0x1000..0x101F, the result is error code 2. Inside that range the target register index is the number minus 0x1000.
- R8: When a transfer has size code `cmd_i[22:20]` = 2, the first word is an RV32 load word (funct3 010, opcode 0000011) if the write bit `cmd_i[16]` is set. If the write bit is clear it is a store word (funct3 010, opcode 0100011). In both cases the base register is x0 and the offset is `DATA_OFS`.
- R9: Size code 3 gives the 64-bit forms: load double or store double (funct3 011). Any other size with transfer set gives error code 2.
- R10: When the transfer bit is clear, the first word is the no-op 0x00000013, whatever the register number and size fields hold.
- R11: The second word is 0x00000013 when the post-execute bit `cmd_i[18]` is set, and the breakpoint 0x00100073 when it is clear.
- R12: On acceptance, `insn_we_o` and `busy_set_o` pulse together, and `go_set_o` is one-hot with the bit of `hart_sel_i` set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | One-cycle command start pulse |
| cmd_i | input | 32 | Abstract command word |
| hart_sel_i | input | HART_W | Index of the selected hart |
| hart_halted_i | input | 1 | Selected hart is halted |
| err_i | input | 3 | Current error code |
| busy_i | input | 1 | A command is already running |
| err_we_o | output | 1 | Pulse: write `err_o` into the error code |
| err_o | output | 3 | New error code |
| insn_we_o | output | 1 | Pulse: write both words to program memory |
| insn0_o | output | 32 | First instruction word |
| insn1_o | output | 32 | Second instruction word |
| busy_set_o | output | 1 | Pulse: set busy |
| go_set_o | output | NHARTS | One-hot pulse: set the hart's go flag |

## Verification
Two functions meet in a single start pulse: the error rules and the instruction encoder. One command may violate several rules at once. The bench provokes this on purpose, for example a non-halted hart given a register number out of range with a bad size, or busy raised together with a non-zero command type. It judges the outcome by whether exactly the highest-priority error is reported, with no instruction write in the same cycle. Random commands are biased toward register numbers near the range edges and toward small size codes. This makes such overlaps frequent. A bench-side model computes each expected result.

// File: rtl/abscmd_pkg.sv
package abscmd_pkg;

  localparam logic [2:0] ERR_NONE    = 3'd0;
  localparam logic [2:0] ERR_BUSY    = 3'd1;
  localparam logic [2:0] ERR_NOTSUP  = 3'd2;
  localparam logic [2:0] ERR_HALTRES = 3'd4;

  localparam logic [31:0] INSN_NOP    = 32'h0000_0013;
  localparam logic [31:0] INSN_EBREAK = 32'h0010_0073;

  localparam logic [6:0] OPC_LOAD  = 7'b0000011;
  localparam logic [6:0] OPC_STORE = 7'b0100011;

  localparam logic [15:0] REG_BASE = 16'h1000;

  // I-type load from ofs(x0) into rd
  function automatic logic [31:0] mk_load(input logic [4:0] rd,
                                          input logic [2:0] f3,
                                          input logic [11:0] ofs);
    logic [31:0] w;
    w        = '0;
    w[31:20] = ofs;
    w[14:12] = f3;
    w[11:7]  = rd;
    w[6:0]   = OPC_LOAD;
    return w;
  endfunction

  // S-type store of rs2 to ofs(x0)
  function automatic logic [31:0] mk_store(input logic [4:0] rs2,
                                           input logic [2:0] f3,
                                           input logic [11:0] ofs);
    logic [31:0] w;
    w        = '0;
    w[31:25] = ofs[11:5];
    w[24:20] = rs2;
    w[14:12] = f3;
    w[11:7]  = ofs[4:0];
    w[6:0]   = OPC_STORE;
    return w;
  endfunction

endpackage

// File: rtl/abscmd_check.sv
module abscmd_check
  import abscmd_pkg::*;
(
  input  logic [31:0] cmd,
  input  logic        halted,
  input  logic [2:0]  err_in,
  input  logic        busy,
  output logic        err_we,
  output logic [2:0]  err_code,
  output logic        accept
);
  logic [7:0]  ctype;
  logic [2:0]  size;
  logic        xfer;
  logic [15:0] regno;
  logic        reg_ok;
  logic        size_ok;
  logic        unused_bits;

  assign ctype       = cmd[31:24];
  assign size        = cmd[22:20];
  assign xfer        = cmd[17];
  assign regno       = cmd[15:0];
  assign unused_bits = ^{cmd[23], cmd[19], cmd[16]};
  assign reg_ok      = (regno[15:5] == REG_BASE[15:5]);
  assign size_ok     = (size == 3'd2) || (size == 3'd3);

  // priority chain; the rule order is part of the behaviour
  always_comb begin
    err_we   = 1'b0;
    err_code = ERR_NONE;
    accept   = 1'b0;
    if (err_in != ERR_NONE) begin
      err_we = 1'b0;
    end else if (busy) begin
      err_we = 1'b1; err_code = ERR_BUSY;
    end else if (ctype != 8'd0) begin
      err_we = 1'b1; err_code = ERR_NOTSUP;
    end else if (!halted) begin
      err_we = 1'b1; err_code = ERR_HALTRES;
    end else if (xfer && !(reg_ok && size_ok)) begin
      err_we = 1'b1; err_code = ERR_NOTSUP;
    end else begin
      accept = 1'b1;
    end
  end
endmodule

// File: rtl/abscmd_encode.sv
module abscmd_encode
  import abscmd_pkg::*;
#(
  parameter logic [11:0] DATA_OFS = 12'h380
) (
  input  logic [31:0] cmd,
  output logic [31:0] insn0,
  output logic [31:0] insn1
);
  logic [4:0] ridx;
  logic [2:0] f3;
  logic       is_wr;
  logic       unused_hi;

  assign ridx      = cmd[4:0];
  assign f3        = cmd[22:20];
  assign is_wr     = cmd[16];
  assign unused_hi = ^{cmd[31:23], cmd[19], cmd[15:5]};

  always_comb begin
    if (!cmd[17])   insn0 = INSN_NOP;
    else if (is_wr) insn0 = mk_load(ridx, f3, DATA_OFS);
    else            insn0 = mk_store(ridx, f3, DATA_OFS);
  end

  assign insn1 = cmd[18] ? INSN_NOP : INSN_EBREAK;
endmodule

// File: rtl/abscmd_godec.sv
module abscmd_godec #(
  parameter int NHARTS = 4,
  localparam int HART_W = (NHARTS > 1) ? $clog2(NHARTS) : 1
) (
  input  logic              en,
  input  logic [HART_W-1:0] sel,
  output logic [NHARTS-1:0] onehot
);
  for (genvar h = 0; h < NHARTS; h++) begin : g_hart
    assign onehot[h] = en && (sel == HART_W'(h));
  end
endmodule

// File: rtl/abscmd_gen.sv
module abscmd_gen
  import abscmd_pkg::*;
#(
  parameter int NHARTS = 4,
  parameter logic [11:0] DATA_OFS = 12'h380,
  localparam int HART_W = (NHARTS > 1) ? $clog2(NHARTS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [31:0]       cmd_i,
  input  logic [HART_W-1:0] hart_sel_i,
  input  logic              hart_halted_i,
  input  logic [2:0]        err_i,
  input  logic              busy_i,
  output logic              err_we_o,
  output logic [2:0]        err_o,
  output logic              insn_we_o,
  output logic [31:0]       insn0_o,
  output logic [31:0]       insn1_o,
  output logic              busy_set_o,
  output logic [NHARTS-1:0] go_set_o
);
  // named internal events for the assertions
  logic              chk_err_we;
  logic [2:0]        chk_code;
  logic              chk_accept;
  logic [31:0]       enc0, enc1;
  logic              take_err, take_cmd;
  logic [NHARTS-1:0] go_next;

  abscmd_check u_check (
    .cmd(cmd_i), .halted(hart_halted_i), .err_in(err_i), .busy(busy_i),
    .err_we(chk_err_we), .err_code(chk_code), .accept(chk_accept)
  );

  abscmd_encode #(.DATA_OFS(DATA_OFS)) u_enc (
    .cmd(cmd_i), .insn0(enc0), .insn1(enc1)
  );

  assign take_err = start_i && chk_err_we;
  assign take_cmd = start_i && chk_accept;

  abscmd_godec #(.NHARTS(NHARTS)) u_go (
    .en(take_cmd), .sel(hart_sel_i), .onehot(go_next)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      err_we_o   <= 1'b0;
      err_o      <= ERR_NONE;
      insn_we_o  <= 1'b0;
      insn0_o    <= '0;
      insn1_o    <= '0;
      busy_set_o <= 1'b0;
      go_set_o   <= '0;
    end else begin
      err_we_o   <= take_err;
      err_o      <= take_err ? chk_code : ERR_NONE;
      insn_we_o  <= take_cmd;
      insn0_o    <= take_cmd ? enc0 : '0;
      insn1_o    <= take_cmd ? enc1 : '0;
      busy_set_o <= take_cmd;
      go_set_o   <= go_next;
    end
  end

  // R2: nothing appears without a start pulse
  a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !start_i |=> !err_we_o && !insn_we_o && !busy_set_o && (go_set_o == '0));

  // R3: a pending error blocks every effect
  a_r3_err_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    start_i && (err_i != ERR_NONE) |=> !err_we_o && !insn_we_o && (go_set_o == '0));

  // R4: busy gives the busy code and nothing else
  a_r4_busy_code: assert property (@(posedge clk) disable iff (!rst_n)
    start_i && (err_i == ERR_NONE) && busy_i |=> err_we_o && (err_o == ERR_BUSY) && !insn_we_o);

  // R5: non-zero command type is not supported
  a_r5_type: assert property (@(posedge clk) disable iff (!rst_n)
    start_i && (err_i == ERR_NONE) && !busy_i && (cmd_i[31:24] != 8'd0)
    |=> err_we_o && (err_o == ERR_NOTSUP));

  // R6: a running hart reports halt/resume before any register rule
  a_r6_running: assert property (@(posedge clk) disable iff (!rst_n)
    start_i && (err_i == ERR_NONE) && !busy_i && (cmd_i[31:24] == 8'd0) && !hart_halted_i
    |=> err_we_o && (err_o == ERR_HALTRES));

  // R12: go flag and busy pulse only with the instruction write
  a_r12_go_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(go_set_o) && ((go_set_o != '0) == insn_we_o) && (busy_set_o == insn_we_o));

  // R12: error and acceptance never coincide
  a_r12_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(err_we_o && insn_we_o));
endmodule

// File: tb/abscmd_gen_tb_top.sv
`timescale 1ns/1ps
module abscmd_gen_tb_top;
  localparam int NH = 4;
  localparam int HW = 2;
  localparam logic [11:0] OFS = 12'h380;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [31:0]   cmd = '0;
  logic [HW-1:0] hsel = '0;
  logic          halted = 1'b0;
  logic [2:0]    err_in = '0;
  logic          busy = 1'b0;
  logic          err_we, insn_we, busy_set;
  logic [2:0]    err_o;
  logic [31:0]   i0, i1;
  logic [NH-1:0] go;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  abscmd_gen #(.NHARTS(NH), .DATA_OFS(OFS)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start), .cmd_i(cmd),
    .hart_sel_i(hsel), .hart_halted_i(halted), .err_i(err_in), .busy_i(busy),
    .err_we_o(err_we), .err_o(err_o), .insn_we_o(insn_we),
    .insn0_o(i0), .insn1_o(i1), .busy_set_o(busy_set), .go_set_o(go)
  );

  typedef logic [1+3+1+32+32+1+NH-1:0] obs_t;

  function automatic obs_t pack_obs(logic ew, logic [2:0] e, logic iw,
                                    logic [31:0] a, logic [31:0] b,
                                    logic bs, logic [NH-1:0] g);
    return {ew, e, iw, a, b, bs, g};
  endfunction

  // reference model written from the requirements
  function automatic obs_t model(logic [31:0] c, logic [HW-1:0] h,
                                 logic hl, logic [2:0] e, logic b);
    logic [31:0] w0, w1;
    logic [4:0]  r;
    logic [2:0]  f;
    bit          rok;
    r   = c[4:0];
    f   = c[22:20];
    rok = (c[15:0] >= 16'h1000) && (c[15:0] <= 16'h101F);
    if (e != 3'd0)                 return '0;
    if (b)                         return pack_obs(1'b1, 3'd1, 1'b0, '0, '0, 1'b0, '0);
    if (c[31:24] != 8'd0)          return pack_obs(1'b1, 3'd2, 1'b0, '0, '0, 1'b0, '0);
    if (!hl)                       return pack_obs(1'b1, 3'd4, 1'b0, '0, '0, 1'b0, '0);
    if (c[17] && (!rok || (f != 3'd2 && f != 3'd3)))
                                   return pack_obs(1'b1, 3'd2, 1'b0, '0, '0, 1'b0, '0);
    if (!c[17])      w0 = 32'h0000_0013;
    else if (c[16])  w0 = {OFS, 5'd0, f, r, 7'h03};
    else             w0 = {OFS[11:5], r, 5'd0, f, OFS[4:0], 7'h23};
    w1 = c[18] ? 32'h0000_0013 : 32'h0010_0073;
    return pack_obs(1'b0, 3'd0, 1'b1, w0, w1, 1'b1, NH'(1) << h);
  endfunction

  function automatic obs_t seen();
    return pack_obs(err_we, err_o, insn_we, i0, i1, busy_set, go);
  endfunction

  task automatic check(string tag, obs_t exp);
    obs_t act;
    act = seen();
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run(string tag, logic [31:0] c, logic [HW-1:0] h,
                     logic hl, logic [2:0] e, logic b);
    cmd = c; hsel = h; halted = hl; err_in = e; busy = b; start = 1'b1;
    @(posedge clk); @(negedge clk);
    start = 1'b0;
    check(tag, model(c, h, hl, e, b));
    cmd = $urandom; halted = $urandom; err_in = '0; busy = 1'b0;
    @(posedge clk); @(negedge clk);
    check({tag, " R2 idle after"}, '0);
  endtask

  function automatic logic [31:0] mkcmd(logic [2:0] sz, logic post, logic xf,
                                        logic wr, logic [15:0] rn);
    return {8'd0, 1'b0, sz, 1'b0, post, xf, wr, rn};
  endfunction

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    check("R1 in reset", '0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after reset", '0);

    run("R3 pending error", mkcmd(3'd2, 0, 1, 1, 16'h1005), 1, 1, 3'd2, 0);
    run("R3 exception code", mkcmd(3'd2, 0, 1, 1, 16'h1005), 1, 1, 3'd3, 1);
    run("R4 busy over bad type", 32'h0100_0000, 0, 0, 3'd0, 1);
    run("R5 type not zero", 32'h0200_0000 | mkcmd(3'd2, 0, 1, 0, 16'h1001), 2, 1, 3'd0, 0);
    run("R6 running with bad reg", mkcmd(3'd5, 0, 1, 0, 16'h2000), 0, 0, 3'd0, 0);
    run("R7 reg 0x0FFF", mkcmd(3'd2, 0, 1, 0, 16'h0FFF), 0, 1, 3'd0, 0);
    run("R7 reg 0x1020", mkcmd(3'd2, 0, 1, 0, 16'h1020), 0, 1, 3'd0, 0);
    run("R7 reg 0x101F", mkcmd(3'd2, 0, 1, 0, 16'h101F), 1, 1, 3'd0, 0);
    run("R8 lw write", mkcmd(3'd2, 0, 1, 1, 16'h100A), 2, 1, 3'd0, 0);
    run("R8 sw read", mkcmd(3'd2, 0, 1, 0, 16'h1000), 3, 1, 3'd0, 0);
    run("R9 ld write", mkcmd(3'd3, 0, 1, 1, 16'h1011), 0, 1, 3'd0, 0);
    run("R9 sd read", mkcmd(3'd3, 1, 1, 0, 16'h1012), 1, 1, 3'd0, 0);
    run("R9 size 4", mkcmd(3'd4, 0, 1, 1, 16'h1003), 1, 1, 3'd0, 0);
    run("R9 size 1", mkcmd(3'd1, 0, 1, 1, 16'h1003), 1, 1, 3'd0, 0);
    run("R10 no transfer junk reg", mkcmd(3'd7, 0, 0, 1, 16'hBEEF), 2, 1, 3'd0, 0);
    run("R11 postexec nop", mkcmd(3'd0, 1, 0, 0, 16'h0000), 3, 1, 3'd0, 0);
    run("R12 hart 3 accept", mkcmd(3'd2, 1, 1, 1, 16'h1007), 3, 1, 3'd0, 0);

    for (int k = 0; k < 400; k++) begin
      logic [31:0] c;
      logic [15:0] rn;
      rn = 16'h0FF8 + 16'($urandom_range(0, 48));
      c  = mkcmd(3'($urandom_range(0, 4)), 1'($urandom), 1'($urandom),
                 1'($urandom), rn);
      if ($urandom_range(0, 9) == 0) c[31:24] = 8'($urandom);
      c[23] = 1'($urandom);
      c[19] = 1'($urandom);
      run("R7 R8 R9 R10 R11 R12 random", c, HW'($urandom),
          ($urandom_range(0, 7) != 0),
          ($urandom_range(0, 7) == 0) ? 3'($urandom_range(1, 7)) : 3'd0,
          ($urandom_range(0, 7) == 0));
    end
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule